// File: doc/BRIEF.md
# Fault Shutdown Sequencer for a Half-Bridge Gate Driver

This block decides, every clock cycle, whether the two gate outputs of a half-bridge driver may follow their control inputs. It watches a digital fault-trip input and a shared shutdown line. The line is bidirectional: any party may pull it low, and this block has an open-drain pulldown on it. The line level comes back as two digitized flags, one for "below the lower threshold" and one for "above the upper threshold".

When a qualified trip arrives, the gate-disable output rises in the same cycle. It does not wait for the line to discharge through its external RC network. From the next clock edge the block holds its pulldown on. The pulldown stays on for at least a minimum number of cycles after the latest trip, and until the line reads below the lower threshold. The block then releases the pulldown so that the external pull-up can recharge the line. The outputs come back only once the line reads above the upper threshold.

A low level put on the line from outside is followed without latching, so the line can carry PWM chopping. The fault input is masked while the supply is in undervoltage. The two line flags pass through a synchronizer of SYNC_STAGES flops (default 2) before the logic uses them. The minimum hold is set by HOLD_MIN (default 4).

Top module: `sdn_seq`

## Requirements
- R1: When trip_i is 1 and uvlo_i is 0, gate_off_o is 1 in that same cycle, with no clock edge in between.
- R2: The first clock edge that samples trip_i=1 with uvlo_i=0 sets pulldown_o to 1.
- R3: After the last qualified trip, pulldown_o stays 1 for at least HOLD_MIN+1 cycles. It clears at the first edge at which the hold count has expired and the synchronized below-threshold flag reads 1. While the line stays above that threshold, the pulldown is never released.
- R4: A qualified trip that arrives while pulldown_o is 1 reloads the hold count, so the release moves later.
- R5: After a trip, gate_off_o returns to 0 only once the pulldown is off and the synchronized above-threshold flag is 1. With the default parameters this happens at the third edge after line_hi_i rises.
- R6: While neither line flag is 1, the enable state does not change: enabled outputs stay enabled and disabled outputs stay disabled.
- R7: An external low on the line (line_lo_i=1, no trip) sets gate_off_o at the third edge. It never sets pulldown_o. When the line returns high, the outputs come back, so nothing is latched.
- R8: While uvlo_i is 1, trip_i has no effect: gate_off_o does not rise and pulldown_o does not rise.
- R9: During reset and after it, pulldown_o is 0 and gate_off_o is 1. gate_off_o stays 1 until the synchronized above-threshold flag has been seen.
- R10: Whenever pulldown_o is 1, gate_off_o is 1, even if the line reads above the upper threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_i | input | 1 | Digitized fault-comparator trip, active high |
| uvlo_i | input | 1 | Supply undervoltage flag, masks trip_i |
| line_lo_i | input | 1 | Shutdown line sensed below the lower threshold |
| line_hi_i | input | 1 | Shutdown line sensed above the upper threshold |
| pulldown_o | output | 1 | Enable for the open-drain pulldown on the shutdown line |
| gate_off_o | output | 1 | Forces both gate outputs low when 1 |

## Verification
The trip reaches gate_off_o in zero cycles, so the bench checks it one time unit after driving trip_i, with no edge in between. pulldown_o is due one edge after the trip. Its release is due HOLD_MIN+1 edges after the last trip, or two synchronizer edges plus one more after line_lo_i rises, whichever is later. Any change of gate_off_o caused by the line flags is due three edges after the flag changes. The bench drives every input on the falling edge and samples outputs on a falling edge an exact number of edges later. It checks both the cycle just before each due edge and the cycle just after it, so a result that comes one cycle early or one cycle late is caught.

// File: rtl/sdn_pkg.sv
package sdn_pkg;

    // Digitized shutdown-line level as seen by the sequencer
    typedef struct packed {
        logic below_lo;
        logic above_hi;
    } line_lvl_t;

    localparam line_lvl_t LINE_RESET = '{below_lo: 1'b0, above_hi: 1'b0};

endpackage

// File: rtl/sdn_sync.sv
module sdn_sync
    import sdn_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  line_lvl_t raw,
    output line_lvl_t synced
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign synced = raw;
        end else begin : g_chain
            line_lvl_t chain_d [STAGES];
            line_lvl_t chain_q [STAGES];

            always_comb begin
                chain_d[0] = raw;
                for (int i = 1; i < STAGES; i++) begin
                    chain_d[i] = chain_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) chain_q[i] <= LINE_RESET;
                end else begin
                    for (int i = 0; i < STAGES; i++) chain_q[i] <= chain_d[i];
                end
            end

            assign synced = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sdn_hold.sv
module sdn_hold #(
    parameter int HOLD_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_ok,
    input  logic below_lo,
    output logic pd
);

    localparam int CW = (HOLD_MIN < 1) ? 1 : $clog2(HOLD_MIN + 1);
    localparam logic [CW-1:0] RELOAD = CW'(HOLD_MIN);

    typedef struct packed {
        logic          pd;
        logic [CW-1:0] cnt;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trip_ok) begin
            // a fresh trip (re)starts the hold
            st_d.pd  = 1'b1;
            st_d.cnt = RELOAD;
        end else if (st_q.pd) begin
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end else if (below_lo) begin
                st_d.pd = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pd: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pd = st_q.pd;

endmodule

// File: rtl/sdn_gate.sv
module sdn_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_ok,
    input  logic pd,
    input  logic below_lo,
    input  logic above_hi,
    output logic en
);

    logic en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (trip_ok || pd || below_lo) begin
            en_d = 1'b0;
        end else if (above_hi) begin
            en_d = 1'b1;
        end
        // neither flag: keep previous state (hysteresis band)
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

    assign en = en_q;

endmodule

// File: rtl/sdn_seq.sv
module sdn_seq
    import sdn_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_MIN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic uvlo_i,
    input  logic line_lo_i,
    input  logic line_hi_i,
    output logic pulldown_o,
    output logic gate_off_o
);

    line_lvl_t line_raw, line_s;
    logic      trip_ok;
    logic      pd;
    logic      en;

    assign line_raw = '{below_lo: line_lo_i, above_hi: line_hi_i};
    assign trip_ok  = trip_i & ~uvlo_i;

    sdn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (line_raw),
        .synced (line_s)
    );

    sdn_hold #(.HOLD_MIN(HOLD_MIN)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .trip_ok  (trip_ok),
        .below_lo (line_s.below_lo),
        .pd       (pd)
    );

    sdn_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .trip_ok  (trip_ok),
        .pd       (pd),
        .below_lo (line_s.below_lo),
        .above_hi (line_s.above_hi),
        .en       (en)
    );

    // fast path: a qualified trip bypasses every register
    assign gate_off_o = ~en | trip_ok;
    assign pulldown_o = pd;

endmodule

// File: rtl/sdn_seq_chk.sv
module sdn_seq_chk #(
    parameter int HOLD_MIN = 4
) (
    input logic clk,
    input logic rst_n,
    input logic trip_i,
    input logic uvlo_i,
    input logic pulldown_o,
    input logic gate_off_o
);

    localparam int SW = $clog2(HOLD_MIN + 2) + 1;
    localparam logic [SW-1:0] SAT = SW'(HOLD_MIN + 1);

    logic [SW-1:0] since_trip;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_trip <= '0;
        end else if (trip_i && !uvlo_i) begin
            since_trip <= '0;
        end else if (since_trip < SAT) begin
            since_trip <= since_trip + 1'b1;
        end
    end

    // R1
    fast_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_i && !uvlo_i) |-> gate_off_o);

    // R2
    pd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_i && !uvlo_i) |=> pulldown_o);

    // R3
    pd_min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulldown_o) |-> (since_trip > SW'(HOLD_MIN)));

    // R8
    uvlo_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uvlo_i && !pulldown_o) |=> !pulldown_o);

    // R10
    pd_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulldown_o |-> gate_off_o);

    // R5
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_off_o) |-> !pulldown_o);

endmodule

bind sdn_seq sdn_seq_chk #(.HOLD_MIN(HOLD_MIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip_i     (trip_i),
    .uvlo_i     (uvlo_i),
    .pulldown_o (pulldown_o),
    .gate_off_o (gate_off_o)
);

// File: tb/sdn_seq_test.sv
module sdn_seq_test;

    localparam int HOLD_MIN = 4;
    localparam int LAT      = 3;   // 2 sync flops + enable register

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trip_i = 1'b0;
    logic uvlo_i = 1'b0;
    logic line_lo_i = 1'b0;
    logic line_hi_i = 1'b1;
    logic pulldown_o, gate_off_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sdn_seq #(.SYNC_STAGES(2), .HOLD_MIN(HOLD_MIN)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .trip_i     (trip_i),
        .uvlo_i     (uvlo_i),
        .line_lo_i  (line_lo_i),
        .line_hi_i  (line_hi_i),
        .pulldown_o (pulldown_o),
        .gate_off_o (gate_off_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_line(input logic lo, input logic hi);
        line_lo_i = lo;
        line_hi_i = hi;
    endtask

    task automatic test_reset;
        step(2);
        check("R9 pulldown in reset", pulldown_o, 1'b0);
        check("R9 gate_off in reset", gate_off_o, 1'b1);
        rst_n = 1'b1;
        step(LAT - 1);
        check("R9 gate_off before line seen", gate_off_o, 1'b1);
        step(1);
        check("R9 enabled after line high", gate_off_o, 1'b0);
        check("R9 pulldown idle", pulldown_o, 1'b0);
    endtask

    task automatic test_trip_line_high;
        trip_i = 1'b1;
        #1;
        check("R1 immediate gate_off", gate_off_o, 1'b1);
        check("R2 pulldown not yet", pulldown_o, 1'b0);
        step(1);
        check("R2 pulldown set", pulldown_o, 1'b1);
        trip_i = 1'b0;
        step(HOLD_MIN + 3);
        check("R3 held while line high", pulldown_o, 1'b1);
        check("R10 gate_off with pulldown", gate_off_o, 1'b1);
        set_line(1'b1, 1'b0);
        step(LAT - 1);
        check("R3 pulldown before low seen", pulldown_o, 1'b1);
        step(1);
        check("R3 pulldown released", pulldown_o, 1'b0);
        check("R5 still off after release", gate_off_o, 1'b1);
        set_line(1'b0, 1'b0);
        step(5);
        check("R6 stays off between thresholds", gate_off_o, 1'b1);
        set_line(1'b0, 1'b1);
        step(LAT - 1);
        check("R5 off one cycle before restart", gate_off_o, 1'b1);
        step(1);
        check("R5 restart on high threshold", gate_off_o, 1'b0);
    endtask

    task automatic test_min_hold;
        set_line(1'b1, 1'b0);
        step(LAT + 1);
        trip_i = 1'b1;
        step(1);
        trip_i = 1'b0;
        check("R2 pulldown set (line low)", pulldown_o, 1'b1);
        step(HOLD_MIN);
        check("R3 minimum hold kept", pulldown_o, 1'b1);
        step(1);
        check("R3 released after minimum hold", pulldown_o, 1'b0);
    endtask

    task automatic test_retrigger;
        trip_i = 1'b1;
        step(1);
        trip_i = 1'b0;
        step(HOLD_MIN - 1);
        trip_i = 1'b1;
        step(1);
        trip_i = 1'b0;
        step(HOLD_MIN);
        check("R4 hold restarted by new trip", pulldown_o, 1'b1);
        step(1);
        check("R4 release after restarted hold", pulldown_o, 1'b0);
        set_line(1'b0, 1'b1);
        step(LAT);
        check("R5 enabled after retrigger", gate_off_o, 1'b0);
    endtask

    task automatic test_pwm_chop;
        for (int k = 0; k < 2; k++) begin
            set_line(1'b1, 1'b0);
            step(LAT - 1);
            check("R7 still on before low seen", gate_off_o, 1'b0);
            step(1);
            check("R7 external low disables", gate_off_o, 1'b1);
            check("R7 no pulldown from external low", pulldown_o, 1'b0);
            set_line(1'b0, 1'b1);
            step(LAT);
            check("R7 not latched, re-enabled", gate_off_o, 1'b0);
        end
    endtask

    task automatic test_band_enabled;
        set_line(1'b0, 1'b0);
        step(6);
        check("R6 stays on between thresholds", gate_off_o, 1'b0);
        set_line(1'b0, 1'b1);
        step(LAT);
    endtask

    task automatic test_uvlo_mask;
        uvlo_i = 1'b1;
        trip_i = 1'b1;
        #1;
        check("R8 no gate_off under uvlo", gate_off_o, 1'b0);
        step(2);
        check("R8 no pulldown under uvlo", pulldown_o, 1'b0);
        check("R8 outputs still enabled", gate_off_o, 1'b0);
        trip_i = 1'b0;
        uvlo_i = 1'b0;
        step(1);
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        test_trip_line_high();
        test_min_hold();
        test_retrigger();
        test_pwm_chop();
        test_band_enabled();
        test_uvlo_mask();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule